// File: doc/BRIEF.md
# Descriptor Vector Fetch Sequencer

This block starts each activation of a data-transfer controller. A hardware request carries a 7-bit source number, and a software request carries a 7-bit index. Either one is turned into the address of a two-byte vector entry. That entry holds only the low 16 bits of a descriptor's location. The block sets the upper byte to fixed bits taken from the on-chip RAM window, checks that the result is a legal place for a descriptor, and then reads the three 32-bit descriptor words. It presents the six fields in parallel and marks completion with a one-cycle strobe.

The block reaches memory through a plain read port. It issues one request at a time and accepts one response for each request. When descriptors are chained, the caller asserts a continue input after a descriptor completes. The sequencer then moves directly to the descriptor twelve bytes further on, without looking at the vector table again.

Top module: `desc_fetch_seq`

## Requirements
- R1: While reset is applied, busy, done, err and rd_req are all 0.
- R2: A software trigger produces one 16-bit read (rd_wide=0) at address 0x000400 + 2*sw_idx. For example, index 0x10 reads 0x000420.
- R3: A hardware trigger reads its vector at 0x000400 + 2*hw_src. When both triggers arrive in the same cycle, the software index is used.
- R4: The descriptor start address is 0xFF in bits 23:16, with bits 15:0 of the vector response below it. Bits 31:16 of that response are ignored.
- R5: A start address is legal only when it is a multiple of four and lies between 0xFFEBC0 and 0xFFEFB4 inclusive, so that all twelve bytes stay below 0xFFEFC0. An illegal start raises err for one cycle, two cycles after the vector response, and issues no descriptor read.
- R6: A legal start issues three 32-bit reads (rd_wide=1) at start, start+4 and start+8. The word layout is fixed:
  - word 0 carries mode_a in bits 31:24 and src_addr in bits 23:0.
  - word 1 carries mode_b in bits 31:24 and dst_addr in bits 23:0.
  - word 2 carries cnt_a in bits 31:16 and cnt_b in bits 15:0.
- R7: rd_req is a one-cycle pulse, and no new request is issued until rd_valid has answered the previous one. An rd_valid that arrives with no read outstanding has no effect on any output.
- R8: done pulses for one cycle, in the cycle after the response to word 2, and the fields are valid at that point. busy is high from the cycle after the accepted trigger up to the cycle in which done or err rises.
- R9: Triggers that arrive while busy is high are ignored.
- R10: chain_go, sampled while idle after a successful fetch, starts a fetch at the previous start + 12 with no vector read. That address is then checked as in R5. chain_go is ignored after reset or after an error, and a trigger in the same cycle takes precedence over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_trig | input | 1 | Software activation request |
| sw_idx | input | 7 | Software vector index |
| hw_trig | input | 1 | Hardware activation request |
| hw_src | input | 7 | Hardware source number |
| chain_go | input | 1 | Continue with the next consecutive descriptor |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | 24 | Read byte address |
| rd_wide | output | 1 | 1 = 32-bit descriptor word, 0 = 16-bit vector |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 32 | Read response data |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | Descriptor complete, one cycle |
| err | output | 1 | Start address rejected, one cycle |
| mode_a | output | 8 | First mode field |
| src_addr | output | 24 | Source address field |
| mode_b | output | 8 | Second mode field |
| dst_addr | output | 24 | Destination address field |
| cnt_a | output | 16 | First count field |
| cnt_b | output | 16 | Second count field |

## Verification
Fetches are started by a software index, by a hardware source number, and by both arriving together. This separates the index-selection paths and shows which one has priority.

Vector words are chosen to land on the lowest legal start, on the highest legal start, on a misaligned address and on an address just below the window. Together these pin down both limits and the alignment rule.

Chains are run from a middle start and from the top start, and chain_go is also tried after an error. Response latency varies between one and three cycles. Stray responses, triggers that arrive mid-fetch, and a trigger combined with chain_go show that state advances only on a legitimate event.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VEC_REQ,
    ST_VEC_WAIT,
    ST_CHECK,
    ST_WORD_REQ,
    ST_WORD_WAIT
  } fetch_state_e;

endpackage

// File: rtl/dfs_trig_sel.sv
module dfs_trig_sel #(
  parameter int             AW       = 24,
  parameter int             IDX_W    = 7,
  parameter logic [AW-1:0]  VEC_BASE = 24'h000400
) (
  input  logic             sw_trig,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic             hw_trig,
  input  logic [IDX_W-1:0] hw_src,
  output logic             go,
  output logic [AW-1:0]    vec_addr
);

  localparam int PAD_W = AW - IDX_W - 1;

  logic [IDX_W-1:0] sel_idx;

  always_comb begin
    go       = sw_trig | hw_trig;
    sel_idx  = sw_trig ? sw_idx : hw_src;
    vec_addr = VEC_BASE + {{PAD_W{1'b0}}, sel_idx, 1'b0};
  end

endmodule

// File: rtl/dfs_win_chk.sv
module dfs_win_chk #(
  parameter int            AW      = 24,
  parameter logic [AW-1:0] WIN_LO  = 24'hFFEBC0,
  parameter logic [AW-1:0] WIN_HI  = 24'hFFEFBF,
  parameter int            SPAN    = 12,
  parameter int            ALIGN_B = 2
) (
  input  logic [AW-1:0] start,
  output logic          ok
);

  logic [AW:0] last_byte;

  always_comb begin
    last_byte = {1'b0, start} + (AW+1)'(SPAN - 1);
    ok = (start[ALIGN_B-1:0] == '0) &&
         (start >= WIN_LO) &&
         (last_byte <= {1'b0, WIN_HI});
  end

endmodule

// File: rtl/desc_fetch_seq.sv
module desc_fetch_seq #(
  parameter int            AW       = 24,
  parameter int            IDX_W    = 7,
  parameter int            VW       = 16,
  parameter int            DW       = 32,
  parameter int            WORDS    = 3,
  parameter logic [AW-1:0] VEC_BASE = 24'h000400,
  parameter logic [AW-1:0] WIN_LO   = 24'hFFEBC0,
  parameter logic [AW-1:0] WIN_HI   = 24'hFFEFBF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_trig,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic             hw_trig,
  input  logic [IDX_W-1:0] hw_src,
  input  logic             chain_go,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  output logic             rd_wide,
  input  logic             rd_valid,
  input  logic [DW-1:0]    rd_data,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [7:0]       mode_a,
  output logic [AW-1:0]    src_addr,
  output logic [7:0]       mode_b,
  output logic [AW-1:0]    dst_addr,
  output logic [15:0]      cnt_a,
  output logic [15:0]      cnt_b
);
  import dfs_pkg::*;

  localparam int            BYTES_W = DW / 8;
  localparam int            SPAN    = WORDS * BYTES_W;
  localparam int            ALIGN_B = $clog2(BYTES_W);
  localparam int            CNT_W   = $clog2(WORDS);
  localparam int            UP_W    = AW - VW;
  localparam logic [UP_W-1:0] UP_BITS = WIN_LO[AW-1:VW];
  localparam logic [AW-1:0] VEC_TOP = VEC_BASE + AW'(2 * ((2 ** IDX_W) - 1));

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  // trigger arbitration and window check
  logic          trig_go;
  logic [AW-1:0] trig_vec;
  logic          start_ok;

  dfs_trig_sel #(.AW(AW), .IDX_W(IDX_W), .VEC_BASE(VEC_BASE)) u_sel (
    .sw_trig (sw_trig),
    .sw_idx  (sw_idx),
    .hw_trig (hw_trig),
    .hw_src  (hw_src),
    .go      (trig_go),
    .vec_addr(trig_vec)
  );

  logic [AW-1:0] base_q, base_d;

  dfs_win_chk #(.AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
                .SPAN(SPAN), .ALIGN_B(ALIGN_B)) u_chk (
    .start(base_q),
    .ok   (start_ok)
  );

  // state
  fetch_state_e   state_q, state_d;
  logic [AW-1:0]  vec_q, vec_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic           done_q, done_d;
  logic           err_q, err_d;
  logic           chain_ok_q, chain_ok_d;
  logic           cap_en;
  logic [WORDS-1:0] word_en;
  logic [DW-1:0]  words_q [WORDS];

  always_comb begin
    state_d    = state_q;
    base_d     = base_q;
    vec_d      = vec_q;
    idx_d      = idx_q;
    done_d     = 1'b0;
    err_d      = 1'b0;
    chain_ok_d = chain_ok_q;
    cap_en     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (trig_go) begin
          vec_d   = trig_vec;
          state_d = ST_VEC_REQ;
        end else if (chain_go && chain_ok_q) begin
          base_d  = base_q + AW'(SPAN);
          state_d = ST_CHECK;
        end
      end
      ST_VEC_REQ: state_d = ST_VEC_WAIT;
      ST_VEC_WAIT: begin
        if (rd_valid) begin
          base_d  = {UP_BITS, rd_data[VW-1:0]};
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!start_ok) begin
          err_d      = 1'b1;
          chain_ok_d = 1'b0;
          state_d    = ST_IDLE;
        end else begin
          idx_d   = '0;
          state_d = ST_WORD_REQ;
        end
      end
      ST_WORD_REQ: state_d = ST_WORD_WAIT;
      ST_WORD_WAIT: begin
        if (rd_valid) begin
          cap_en = 1'b1;
          if (idx_q == CNT_W'(WORDS - 1)) begin
            done_d     = 1'b1;
            chain_ok_d = 1'b1;
            state_d    = ST_IDLE;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_WORD_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q    <= ST_IDLE;
      base_q     <= '0;
      vec_q      <= '0;
      idx_q      <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      chain_ok_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      base_q     <= base_d;
      vec_q      <= vec_d;
      idx_q      <= idx_d;
      done_q     <= done_d;
      err_q      <= err_d;
      chain_ok_q <= chain_ok_d;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_wen
    assign word_en[g] = cap_en && (idx_q == CNT_W'(g));
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      for (int i = 0; i < WORDS; i++) words_q[i] <= '0;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (word_en[i]) words_q[i] <= rd_data;
      end
    end
  end

  // outputs
  always_comb begin
    rd_req   = (state_q == ST_VEC_REQ) || (state_q == ST_WORD_REQ);
    rd_wide  = (state_q == ST_WORD_REQ);
    rd_addr  = (state_q == ST_VEC_REQ) ? vec_q
                                       : base_q + (AW'(idx_q) << ALIGN_B);
    busy     = (state_q != ST_IDLE);
    done     = done_q;
    err      = err_q;
    mode_a   = words_q[0][DW-1 -: 8];
    src_addr = words_q[0][AW-1:0];
    mode_b   = words_q[1][DW-1 -: 8];
    dst_addr = words_q[1][AW-1:0];
    cnt_a    = words_q[2][DW-1 -: 16];
    cnt_b    = words_q[2][15:0];
  end

  // assertions
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_q)
    rd_req |=> !rd_req);  // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> !done);  // R8
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(busy) |-> (done || err));  // R8
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_q)
    !(done && err));  // R5
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_req && !rd_wide) |-> (rd_addr >= VEC_BASE && rd_addr <= VEC_TOP && !rd_addr[0]));  // R2
  AST_WORD_IN_WIN: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_req && rd_wide) |-> (rd_addr[ALIGN_B-1:0] == '0 && rd_addr >= WIN_LO && rd_addr <= WIN_HI));  // R6

endmodule

// File: tb/desc_fetch_seq_test.sv
module desc_fetch_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_trig = 1'b0, hw_trig = 1'b0, chain_go = 1'b0;
  logic [6:0]  sw_idx = '0, hw_src = '0;
  logic        rd_req, rd_wide, rd_valid = 1'b0;
  logic [23:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic        busy, done, err;
  logic [7:0]  mode_a, mode_b;
  logic [23:0] src_addr, dst_addr;
  logic [15:0] cnt_a, cnt_b;

  always #2 clk = ~clk;

  desc_fetch_seq uut (
    .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .sw_idx(sw_idx),
    .hw_trig(hw_trig), .hw_src(hw_src), .chain_go(chain_go),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_wide(rd_wide),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
    .err(err), .mode_a(mode_a), .src_addr(src_addr), .mode_b(mode_b),
    .dst_addr(dst_addr), .cnt_a(cnt_a), .cnt_b(cnt_b)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc++;

  // reference model state
  int          busy_from = 1 << 30;
  int          busy_end = 0;
  bit          end_known = 1'b1, end_is_err = 1'b0;
  bit          prev_ok = 1'b0, mon_en = 1'b0, spur = 1'b0;
  int          lat = 1;
  logic [23:0] cur_start = '0, prev_start = '0;
  int          q_addr[$];
  int          q_kind[$];
  string       q_tag[$];
  logic [15:0] vtab [int];

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] dword(input logic [23:0] a);
    return {a[7:0] ^ 8'h3C, a ^ 24'h5A5A5A};
  endfunction

  function automatic bit start_ok(input logic [23:0] s);
    return (s[1:0] == 2'b00) && (s >= 24'hFFEBC0) && (s <= 24'hFFEFB4);
  endfunction

  task automatic plan_words(input int trig_cyc, input bit from_chain);
    if (start_ok(cur_start)) begin
      for (int w = 0; w < 3; w++) begin
        q_addr.push_back(int'(cur_start) + 4 * w);
        q_kind.push_back(w + 1);
        q_tag.push_back(from_chain ? "R10 R6" : "R4 R6");
      end
    end else begin
      end_known  = 1'b1;
      end_is_err = 1'b1;
      busy_end   = trig_cyc;
      prev_ok    = 1'b0;
    end
  endtask

  // memory responder, also updates the model from the vector word
  initial begin
    int          a, k, vi;
    string       tg;
    logic [15:0] vw;
    forever begin
      @(posedge clk); #1;
      rd_valid = 1'b0;
      if (mon_en && rd_req) begin
        if (q_addr.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7 R9 unexpected read actual %h expected none", rd_addr);
          a = int'(rd_addr); k = rd_wide ? 1 : 0; tg = "";
        end else begin
          a = q_addr.pop_front(); k = q_kind.pop_front(); tg = q_tag.pop_front();
          chk({tg, " read address"}, rd_addr, a);
          chk({tg, " read width"}, rd_wide, (k != 0));
        end
        repeat (lat) @(posedge clk);
        #1;
        rd_valid = 1'b1;
        if (k == 0) begin
          vi = (a - 'h400) / 2;
          vw = vtab.exists(vi) ? vtab[vi] : 16'h0000;
          rd_data = {16'hBEEF, vw};
          cur_start = {8'hFF, vw};
          plan_words(cyc + 2, 1'b0);
        end else begin
          rd_data = dword(a[23:0]);
          if (k == 3) begin
            end_known  = 1'b1;
            end_is_err = 1'b0;
            busy_end   = cyc + 1;
            prev_ok    = 1'b1;
            prev_start = cur_start;
          end
        end
      end else if (mon_en && spur) begin
        rd_valid = 1'b1;
        rd_data  = 32'h1234EBC0;
        spur     = 1'b0;
      end
    end
  end

  // per-cycle comparison against the model
  bit exp_busy, exp_done, exp_err;
  always @(negedge clk) begin
    if (mon_en) begin
      exp_busy = (cyc >= busy_from) && !(end_known && cyc >= busy_end);
      exp_done = end_known && !end_is_err && (cyc == busy_end);
      exp_err  = end_known && end_is_err && (cyc == busy_end);
      chk("R8 busy", busy, exp_busy);
      chk("R8 done", done, exp_done);
      chk("R5 err", err, exp_err);
      if (exp_done) begin
        chk("R6 mode_a",   mode_a,   dword(cur_start)[31:24]);
        chk("R6 src_addr", src_addr, dword(cur_start)[23:0]);
        chk("R6 mode_b",   mode_b,   dword(cur_start + 24'd4)[31:24]);
        chk("R6 dst_addr", dst_addr, dword(cur_start + 24'd4)[23:0]);
        chk("R6 cnt_a",    cnt_a,    dword(cur_start + 24'd8)[31:16]);
        chk("R6 cnt_b",    cnt_b,    dword(cur_start + 24'd8)[15:0]);
      end
    end
  end

  // start a fetch at a negedge; the model follows the requirements
  task automatic trig(input bit sw, input int sidx, input bit hw, input int hidx, input bit ch);
    @(negedge clk);
    sw_trig = sw; sw_idx = 7'(sidx); hw_trig = hw; hw_src = 7'(hidx); chain_go = ch;
    if (sw || hw) begin
      busy_from = cyc + 1; end_known = 1'b0;
      q_addr.push_back('h400 + 2 * (sw ? sidx : hidx));
      q_kind.push_back(0);
      q_tag.push_back(sw ? (ch ? "R10 R2" : "R2") : "R3");
    end else if (ch && prev_ok) begin
      busy_from = cyc + 1; end_known = 1'b0;
      cur_start = prev_start + 24'd12;
      plan_words(cyc + 2, 1'b1);
    end
    @(negedge clk);
    sw_trig = 1'b0; hw_trig = 1'b0; chain_go = 1'b0;
  endtask

  task automatic wait_idle();
    while (!(end_known && cyc > busy_end)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [63:0] snap;
    vtab[16'h10] = 16'hEBC0;
    vtab[16'h05] = 16'hEC40;
    vtab[16'h7F] = 16'hEFB4;
    vtab[16'h01] = 16'hED80;
    vtab[16'h02] = 16'hEC02;
    vtab[16'h03] = 16'hEBBC;
    vtab[16'h04] = 16'hED00;
    vtab[16'h06] = 16'hEE00;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 err in reset", err, 0);
    chk("R1 rd_req in reset", rd_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    // R10: chain before any successful fetch is ignored
    trig(0, 0, 0, 0, 1);
    repeat (4) @(negedge clk);
    chk("R10 chain ignored after reset", busy, 0);

    // R2: software index 0x10 -> vector 0x420, lowest legal start
    lat = 1;
    trig(1, 'h10, 0, 0, 0); wait_idle();
    // R3: hardware source, longer latency
    lat = 3;
    trig(0, 0, 1, 'h05, 0); wait_idle();
    // R3: both together, software index 0x7F wins, highest legal start
    lat = 2;
    trig(1, 'h7F, 1, 'h01, 0); wait_idle();
    // R10 + R5: chain from top start crosses the window end -> err
    trig(0, 0, 0, 0, 1); wait_idle();
    // R10: chain after error ignored
    trig(0, 0, 0, 0, 1);
    repeat (4) @(negedge clk);
    chk("R10 chain ignored after error", busy, 0);
    // R5: misaligned start and start below window
    lat = 1;
    trig(1, 'h02, 0, 0, 0); wait_idle();
    trig(0, 0, 1, 'h03, 0); wait_idle();
    // R10: chain twice from a middle start
    trig(1, 'h04, 0, 0, 0); wait_idle();
    lat = 2;
    trig(0, 0, 0, 0, 1); wait_idle();
    trig(0, 0, 0, 0, 1); wait_idle();
    chk("R10 chained start", cur_start, 24'hFFED18);

    // R9: triggers during a fetch are ignored
    lat = 3;
    trig(1, 'h06, 0, 0, 0);
    repeat (3) @(negedge clk);
    sw_trig = 1'b1; sw_idx = 7'h10; hw_trig = 1'b1; hw_src = 7'h05;
    @(negedge clk);
    sw_trig = 1'b0; hw_trig = 1'b0;
    wait_idle();
    repeat (6) @(negedge clk);
    chk("R9 no pending reads after ignored trigger", q_addr.size(), 0);
    chk("R9 idle after ignored trigger", busy, 0);

    // R7: stray response while idle changes nothing
    snap = {mode_a, src_addr, cnt_a, cnt_b};
    spur = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 stray response fields", {mode_a, src_addr, cnt_a, cnt_b}, snap);
    chk("R7 stray response busy", busy, 0);

    // R10: trigger beats chain_go in the same cycle
    lat = 1;
    trig(1, 'h10, 0, 0, 1); wait_idle();
    chk("R10 trigger precedence start", cur_start, 24'hFFEBC0);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule